// File: doc/BRIEF.md
# Clock Output Source Selector and Divider

This block drives one clock-output pin from one of four clock sources, divided by a value that software programs. It is reached through a small synchronous register bus. Each source arrives as a one-cycle tick enable in the system clock domain, so the output is a divided pulse train in that domain rather than a true asynchronous clock.

Writing a new source code only stores it as a pending choice. The choice becomes active when software writes 0 and then 1 to the update bit. Software then polls that bit until it reads 1. The switch itself waits for a low phase of the output. The divider count then restarts on the new source, so no short pulse appears.

The divider is a state machine with four states:
- ST_OFF: the divide value is 0 and the output is held low.
- ST_PASS: the divide value is 1 and the output follows the source ticks.
- ST_LOW: the low phase of a divided period.
- ST_HIGH: the high phase of a divided period.

Its transitions are:
- Any state goes to ST_OFF when the divide value is 0.
- Any state goes to ST_PASS when the divide value is 1.
- ST_OFF and ST_PASS go to ST_LOW when the divide value is 2 or more.
- ST_LOW goes to ST_HIGH on the tick that completes the low count.
- ST_HIGH goes to ST_LOW on the tick that completes the high count.
- A source switch reloads the state from the divide value.

Top module: `clkout_unit`

## Requirements
- R1: After reset the pending source reads 0, the update bit reads 0 and the divide value reads 0. Source 0 is active and the output is low.
- R2: Source code 0 selects src_tick[0], the internal RC stream. Code 1 selects src_tick[1], the system oscillator. Code 2 selects src_tick[2], the watchdog oscillator. Code 3 selects src_tick[3], the main clock.
- R3: The register map is as follows.
  - Offset 0x0E0 holds the 2-bit pending source in bits 1:0.
  - Offset 0x0E4 holds the update bit in bit 0.
  - Offset 0x0E8 holds the divide value in bits 7:0.
  - All other bits of these registers read 0 and ignore writes.
- R4: A read of any other offset returns 0, and a write to it changes nothing.
- R5: Writing the source register alone leaves the active source unchanged.
- R6: A write of 1 to the update bit arms a switch only when the last value written to that bit was 0. While a switch is armed, the update bit reads 0. It reads 1 once the pending source has become active.
- R7: A write of 1 to the update bit when the last value written to it was already 1 does not arm a switch.
- R8: A divide value of 0 holds the output low from the second cycle after it takes effect.
- R9: A divide value of 1 makes the output high in the cycle after each tick of the active source.
- R10: A divide value D of 2 or more gives an output period of D source ticks. The output is high for floor(D/2) ticks and low for the remaining ticks.
- R11: An armed switch completes only while the output is low. The divider then restarts its count on the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | One tick enable per clock source |
| clk_out | output | 1 | Divided clock output |

## Verification
The assertions check on every cycle the following properties:
- Reserved read bits are zero.
- A repeated 1 on the update bit does not arm a switch.
- The active source holds while no switch is armed, and a switch happens only while the output is low.
- The active source after a switch equals the pending source.
- A zero divide value forces the output low.

The phase lengths, the source encoding, the polling of the update bit and the absence of runt pulses across a switch depend on tick patterns over many cycles. Only the bench scenarios can show those, by comparing against a cycle-by-cycle reference model and measuring pulse widths.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_PASS = 2'd3
    } div_state_e;

    localparam logic [11:0] OFS_SRC = 12'h0E0;
    localparam logic [11:0] OFS_UPD = 12'h0E4;
    localparam logic [11:0] OFS_DIV = 12'h0E8;

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              switch_ack,
    output logic              upd_req,
    output logic [SEL_W-1:0]  sel_pend,
    output logic [DIV_W-1:0]  div_val
);

    logic [SEL_W-1:0] sel_pend_q;
    logic [DIV_W-1:0] div_q;
    logic             uen_q;
    logic             upd_q;
    logic             hit_src, hit_upd, hit_div;
    logic             unused_wbits;

    assign hit_src = (addr == ADDR_W'(OFS_SRC));
    assign hit_upd = (addr == ADDR_W'(OFS_UPD));
    assign hit_div = (addr == ADDR_W'(OFS_DIV));
    assign unused_wbits = ^wdata[DATA_W-1:DIV_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_pend_q <= '0;
            div_q      <= '0;
            uen_q      <= 1'b0;
            upd_q      <= 1'b0;
        end else begin
            if (switch_ack) upd_q <= 1'b0;
            if (wr_en) begin
                if (hit_src) sel_pend_q <= wdata[SEL_W-1:0];
                if (hit_div) div_q <= wdata[DIV_W-1:0];
                if (hit_upd) begin
                    uen_q <= wdata[0];
                    if (wdata[0] && !uen_q) upd_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_src)      rdata[SEL_W-1:0] = sel_pend_q;
        else if (hit_upd) rdata[0]         = uen_q & ~upd_q;
        else if (hit_div) rdata[DIV_W-1:0] = div_q;
    end

    assign upd_req  = upd_q;
    assign sel_pend = sel_pend_q;
    assign div_val  = div_q;

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:DIV_W] == '0);

    // R6
    arm_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_upd && wdata[0] && !uen_q) |=> upd_q);

    // R7
    relatch_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_upd && wdata[0] && uen_q && !upd_q) |=> !upd_q);

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
    import clkout_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               upd_req,
    input  logic [SEL_W-1:0]   pend_sel,
    input  logic [DIV_W-1:0]   div_val,
    output logic               switch_ack,
    output logic               clk_out
);

    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] act_q, act_d;
    logic             pass_q, pass_d;
    logic             tick, low_ok;
    logic [DIV_W-1:0] hi_lim, lo_lim;
    logic [DIV_W:0]   cnt_inc;

    assign tick    = src_tick[act_q];
    assign hi_lim  = div_val >> 1;
    assign lo_lim  = div_val - hi_lim;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        unique case (state_q)
            ST_OFF, ST_LOW: low_ok = 1'b1;
            ST_HIGH:        low_ok = 1'b0;
            ST_PASS:        low_ok = !pass_q;
        endcase
    end

    assign switch_ack = upd_req && low_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            act_q   <= '0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            pass_q  <= pass_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        pass_d  = pass_q;
        if (switch_ack) begin
            act_d  = pend_sel;
            cnt_d  = '0;
            pass_d = 1'b0;
            if (div_val == '0)      state_d = ST_OFF;
            else if (div_val == 1)  state_d = ST_PASS;
            else                    state_d = ST_LOW;
        end else if (div_val == '0) begin
            state_d = ST_OFF;
            cnt_d   = '0;
            pass_d  = 1'b0;
        end else if (div_val == 1) begin
            state_d = ST_PASS;
            cnt_d   = '0;
            pass_d  = tick;
        end else begin
            unique case (state_q)
                ST_OFF, ST_PASS: begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                    pass_d  = 1'b0;
                end
                ST_LOW: if (tick) begin
                    if (cnt_inc >= {1'b0, lo_lim}) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[DIV_W-1:0];
                    end
                end
                ST_HIGH: if (tick) begin
                    if (cnt_inc >= {1'b0, hi_lim}) begin
                        state_d = ST_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[DIV_W-1:0];
                    end
                end
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (state_q)
            ST_HIGH: clk_out = 1'b1;
            ST_PASS: clk_out = pass_q;
            default: clk_out = 1'b0;
        endcase
    end

    // R8
    div_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val == '0) |=> !clk_out);

    // R5
    source_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_req |=> $stable(act_q));

    // R11
    switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_ack |-> !clk_out);

    // R6
    switch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_ack |=> (act_q == $past(pend_sel)));

    // R9
    pass_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && div_val == 1 && tick && !switch_ack) |=> clk_out);

endmodule

// File: rtl/clkout_unit.sv
module clkout_unit #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 8,
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               clk_out
);

    localparam int SEL_W = $clog2(NUM_SRC);

    logic             upd_req, switch_ack;
    logic [SEL_W-1:0] sel_pend;
    logic [DIV_W-1:0] div_val;

    clkout_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_W(SEL_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .switch_ack (switch_ack),
        .upd_req    (upd_req),
        .sel_pend   (sel_pend),
        .div_val    (div_val)
    );

    clkout_divider #(
        .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)
    ) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick   (src_tick),
        .upd_req    (upd_req),
        .pend_sel   (sel_pend),
        .div_val    (div_val),
        .switch_ack (switch_ack),
        .clk_out    (clk_out)
    );

endmodule

// File: tb/test_clkout_unit.sv
module test_clkout_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic        clk_out;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;
    int cyc_all = 0;
    bit done = 1'b0;

    // reference model state
    int m_pend, m_uen, m_div, m_act, m_upd, m_ph, m_cnt, m_pass;

    clkout_unit i_clkout_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .clk_out(clk_out)
    );

    always #10 clk = ~clk;

    // tick streams: src0 every 2 cycles, src1 every 3, src2 every 5, src3 every cycle
    always @(posedge clk) begin
        #2;
        tcnt++;
        src_tick = {1'b1, (tcnt % 5) == 0, (tcnt % 3) == 0, (tcnt % 2) == 0};
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_rd(input logic [11:0] a);
        case (a)
            12'h0E0: return m_pend;
            12'h0E4: return (m_uen != 0 && m_upd == 0) ? 1 : 0;
            12'h0E8: return m_div;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_uen = 0; m_div = 0; m_act = 0;
            m_upd = 0; m_ph = 0; m_cnt = 0; m_pass = 0;
        end else begin
            int tk, go, n_ph, n_cnt, n_pass, n_act, n_upd, hi, lo;
            tk = src_tick[m_act];
            hi = m_div / 2;
            lo = m_div - hi;
            go = (m_upd != 0 && (m_ph == 0 || m_ph == 1 || (m_ph == 3 && m_pass == 0))) ? 1 : 0;
            n_ph = m_ph; n_cnt = m_cnt; n_pass = m_pass; n_act = m_act; n_upd = m_upd;
            if (go != 0) begin
                n_act = m_pend; n_cnt = 0; n_pass = 0;
                n_ph = (m_div == 0) ? 0 : ((m_div == 1) ? 3 : 1);
                n_upd = 0;
            end else if (m_div == 0) begin
                n_ph = 0; n_cnt = 0; n_pass = 0;
            end else if (m_div == 1) begin
                n_ph = 3; n_cnt = 0; n_pass = tk;
            end else if (m_ph == 0 || m_ph == 3) begin
                n_ph = 1; n_cnt = 0; n_pass = 0;
            end else if (tk != 0) begin
                if (m_cnt + 1 >= ((m_ph == 1) ? lo : hi)) begin
                    n_ph = (m_ph == 1) ? 2 : 1;
                    n_cnt = 0;
                end else begin
                    n_cnt = m_cnt + 1;
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    12'h0E0: m_pend = int'(bus_wdata & 32'h3);
                    12'h0E4: begin
                        if (bus_wdata[0] && m_uen == 0) n_upd = 1;
                        m_uen = int'(bus_wdata[0]);
                    end
                    12'h0E8: m_div = int'(bus_wdata & 32'hFF);
                    default: ;
                endcase
            end
            m_ph = n_ph; m_cnt = n_cnt; m_pass = n_pass; m_act = n_act; m_upd = n_upd;
        end
    end

    // per-cycle comparison against the model (R10/R11 phase and switch timing)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_out;
            exp_out = (m_ph == 2 || (m_ph == 3 && m_pass != 0)) ? 1 : 0;
            check(int'(clk_out) == exp_out, "R10/R11 model clk_out", int'(clk_out), exp_out);
            check(int'(bus_rdata) == model_rd(bus_addr), "R3 model rdata",
                  int'(bus_rdata), model_rd(bus_addr));
        end
    end

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_all, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output int v);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        v = int'(bus_rdata);
    endtask

    task automatic wait_val(input logic v);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (clk_out == v) break;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_val(1'b0);
        wait_val(1'b1);
        hi = 1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (clk_out) hi++; else break;
        end
        lo = 1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!clk_out) lo++; else break;
        end
    endtask

    task automatic handshake_poll(input string req);
        int v;
        bus_write(12'h0E4, 32'h0);
        bus_write(12'h0E4, 32'h1);
        v = 0;
        for (int k = 0; k < 200; k++) begin
            bus_read(12'h0E4, v);
            if (v == 1) break;
        end
        check(v == 1, req, v, 1);
    endtask

    initial begin
        int v, hi, lo;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        bus_read(12'h0E0, v); check(v == 0, "R1 source reset", v, 0);
        bus_read(12'h0E4, v); check(v == 0, "R1 update reset", v, 0);
        bus_read(12'h0E8, v); check(v == 0, "R1 divide reset", v, 0);
        check(clk_out == 1'b0, "R1 output low", int'(clk_out), 0);

        // R3 field widths and reserved bits
        bus_write(12'h0E0, 32'hFFFF_FFFE);
        bus_read(12'h0E0, v); check(v == 2, "R3 source field", v, 2);
        bus_write(12'h0E8, 32'hFFFF_FF04);
        bus_read(12'h0E8, v); check(v == 4, "R3 divide field", v, 4);
        bus_write(12'h0E4, 32'hFFFF_FFFE);
        bus_read(12'h0E4, v); check(v == 0, "R3 update field", v, 0);

        // R4 unmapped offsets
        bus_write(12'h0EC, 32'hFFFF_FFFF);
        bus_read(12'h0EC, v); check(v == 0, "R4 unmapped read", v, 0);
        bus_read(12'h000, v); check(v == 0, "R4 offset zero read", v, 0);
        bus_read(12'h0E0, v); check(v == 2, "R4 source untouched", v, 2);
        bus_read(12'h0E8, v); check(v == 4, "R4 divide untouched", v, 4);

        // R5 pending source not active yet: src0 (period 2), divide 4
        measure(hi, lo);
        check(hi == 4, "R5 high on old source", hi, 4);
        check(lo == 4, "R5 low on old source", lo, 4);

        // R6 arm with 1 after the last written 0, poll, then code 2 = src2 (period 5)
        bus_write(12'h0E4, 32'h1);
        v = 0;
        for (int k = 0; k < 200; k++) begin
            bus_read(12'h0E4, v);
            if (v == 1) break;
        end
        check(v == 1, "R6 update completes", v, 1);
        measure(hi, lo);
        check(hi == 10, "R2 code 2 watchdog stream", hi, 10);

        // R7 repeated 1 does not switch
        bus_write(12'h0E0, 32'h1);
        bus_write(12'h0E4, 32'h1);
        measure(hi, lo);
        check(hi == 10, "R7 no relatch", hi, 10);

        // R2 code 1 = src1 (period 3)
        handshake_poll("R6 second update");
        measure(hi, lo);
        check(hi == 6, "R2 code 1 sysosc high", hi, 6);
        check(lo == 6, "R10 even divide low", lo, 6);

        // R10 odd divide
        bus_write(12'h0E8, 32'd5);
        measure(hi, lo);
        check(hi == 6, "R10 odd divide high", hi, 6);
        check(lo == 9, "R10 odd divide low", lo, 9);

        // R9 divide 1 passes ticks
        bus_write(12'h0E8, 32'd1);
        measure(hi, lo);
        check(hi == 1, "R9 pass high", hi, 1);
        check(lo == 2, "R9 pass low", lo, 2);

        // R2 code 3 = main clock, every cycle: constant high
        bus_write(12'h0E0, 32'h3);
        handshake_poll("R6 third update");
        repeat (3) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(clk_out == 1'b1, "R2 code 3 main stream", int'(clk_out), 1);
        end

        // R11 switch waits for a low phase
        bus_write(12'h0E8, 32'd8);
        bus_write(12'h0E0, 32'h2);
        handshake_poll("R6 fourth update");
        bus_write(12'h0E0, 32'h0);
        wait_val(1'b0);
        wait_val(1'b1);
        bus_write(12'h0E4, 32'h0);
        bus_write(12'h0E4, 32'h1);
        bus_read(12'h0E4, v);
        check(v == 0 && clk_out == 1'b1, "R11 pending during high", v, 0);
        v = 0;
        for (int k = 0; k < 200; k++) begin
            bus_read(12'h0E4, v);
            if (v == 1) break;
        end
        check(v == 1, "R11 completes after high", v, 1);
        measure(hi, lo);
        check(hi == 8, "R11 restart on new source", hi, 8);

        // R8 divide 0
        bus_write(12'h0E8, 32'd0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check(clk_out == 1'b0, "R8 stopped low", int'(clk_out), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule